// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DRAM row must be refreshed and slots those refresh operations between ordinary memory accesses. A programmable interval timer raises refresh demand. A row counter names the next row to refresh. A small issue stage arbitrates between pending refresh work and the access arbiter's requests. Each refresh is a row-only operation: it carries no column and returns no data.

Two schedules are supported. In distributed mode, one refresh is owed per interval. In burst mode, every row is refreshed back to back once per full retention period. The command can carry the row address from the internal counter (explicit-row style) or be sent bare, in which case the device's own counter selects the row. An over-temperature input halves the timer period. A sleep input stops host refreshes and signals that the device is refreshing itself. If an access in flight delays refresh, the demand is queued, and a full queue blocks new grants.

Top module: `refresh_sched`

## Requirements
- R1: During reset no command is issued, `ref_busy_o` and `self_ref_o` are low, and the row counter is zero. The first command appears INTERVAL to INTERVAL+2 clock cycles after reset is released.
- R2: In distributed mode with no access activity, consecutive refresh commands are exactly INTERVAL cycles apart.
- R3: With `cbr_mode_i`=0, each command drives `ref_addr_vld_o`=1 and `ref_row_o` with the counter value. The counter starts at 0, rises by one per command (in either style) and wraps from ROWS-1 to 0.
- R4: With `cbr_mode_i`=1, commands drive `ref_addr_vld_o`=0 and `ref_row_o`=0.
- R5: `ref_busy_o` is high for exactly BUSY cycles, starting in the cycle of `ref_cmd_o`. `acc_gnt_o` is never high while `ref_busy_o` is high.
- R6: With `hot_i`=1, the timer period is halved: distributed commands come INTERVAL/2 cycles apart.
- R7: In burst mode, once every ROWS*INTERVAL cycles, ROWS commands are issued BUSY cycles apart, and no grant is given in between.
- R8: While `acc_busy_i` is high, no command is issued and owed refreshes are queued. After it falls, the queued refreshes are issued back to back, BUSY cycles apart.
- R9: With fewer than MAX_PEND refreshes queued, requests are still granted. Once MAX_PEND are queued, `acc_gnt_o` stays low until the queue drains.
- R10: While `sleep_i` is high, no command is issued and `self_ref_o` is high one cycle later. Queued work and the timer are cleared, and the first command after wake comes INTERVAL to INTERVAL+2 cycles later.
- R11: `pass_done_o` pulses together with the command for row ROWS-1 and at no other time.
- R12: Two refresh commands are never less than BUSY cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_mode_i | input | 1 | 1: burst schedule, 0: distributed |
| cbr_mode_i | input | 1 | 1: commands without address, 0: explicit row |
| hot_i | input | 1 | Over-temperature flag, halves the period |
| sleep_i | input | 1 | Hand refresh over to the device |
| acc_req_i | input | 1 | Arbiter requests a normal access |
| acc_busy_i | input | 1 | A normal access is in progress |
| acc_gnt_o | output | 1 | Grant to the normal access |
| ref_cmd_o | output | 1 | One-cycle refresh command |
| ref_addr_vld_o | output | 1 | `ref_row_o` is meaningful |
| ref_row_o | output | $clog2(ROWS) | Row being refreshed |
| ref_busy_o | output | 1 | Refresh occupies the memory |
| self_ref_o | output | 1 | Device self-refresh indication |
| pass_done_o | output | 1 | Pulse when the last row is refreshed |

## Verification
Every cycle, the bound checker enforces the local rules of the command stream: no grant during a busy window, no command while self-refresh is shown, the address-valid and pass pulses only alongside a command, a command always opening a busy window, and no two commands in adjacent cycles. Timing that spans many cycles can only be shown by the bench scenarios. These cover the first command after reset or wake, the exact distributed and halved spacing, burst cadence and full-array coverage, queue drain after a long access, and grant blocking at the queue limit.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    SCHED_DIST  = 1'b0,
    SCHED_BURST = 1'b1
  } sched_e;

  function automatic int unsigned period_of(int unsigned base, logic hot);
    return hot ? (base / 2) : base;
  endfunction
endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int unsigned ROWS     = 8192,
  parameter int unsigned INTERVAL = 1040
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic burst_i,
  input  logic hot_i,
  output logic tick_o
);
  import refresh_pkg::*;

  localparam int unsigned FULL_PERIOD = INTERVAL * ROWS;
  localparam int unsigned TW          = $clog2(FULL_PERIOD + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  sched_e        sched;

  assign sched = sched_e'(burst_i);

  always_comb begin
    if (sched == SCHED_BURST) lim = TW'(period_of(FULL_PERIOD, hot_i));
    else                      lim = TW'(period_of(INTERVAL, hot_i));
  end

  // >= so that a shorter period taking effect mid-count still fires
  assign tick_o = (cnt_q >= (lim - TW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROWS = 8192
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    wrap_o
);
  localparam int unsigned RW = $clog2(ROWS);

  logic [RW-1:0] row_q;

  assign row_o  = row_q;
  assign wrap_o = adv_i && (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (wrap_o) row_q <= '0;
    else if (adv_i)  row_q <= row_q + RW'(1);
  end
endmodule

// File: rtl/ref_issue.sv
module ref_issue #(
  parameter int unsigned ROWS     = 8192,
  parameter int unsigned BUSY     = 4,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic burst_i,
  input  logic sleep_i,
  input  logic acc_req_i,
  input  logic acc_busy_i,
  output logic issue_o,
  output logic gnt_o,
  output logic busy_o
);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam int unsigned BW = $clog2(ROWS + 1);
  localparam int unsigned CW = $clog2(BUSY + 1);

  logic [PW-1:0] pend_q;
  logic [BW-1:0] left_q;
  logic [CW-1:0] win_q;
  logic          work, take_burst, take_pend, add_pend, full;

  assign full       = (pend_q == PW'(MAX_PEND));
  assign work       = (left_q != '0) || (pend_q != '0);
  // next command may start in the last cycle of the current window
  assign issue_o    = work && !sleep_i && !acc_busy_i && (win_q <= CW'(1));
  assign take_burst = issue_o && (left_q != '0);
  assign take_pend  = issue_o && (left_q == '0);
  assign add_pend   = tick_i && !burst_i && !full;
  assign busy_o     = (win_q != '0);
  assign gnt_o      = acc_req_i && (win_q == '0) && !issue_o && (left_q == '0) && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      left_q <= '0;
    end else if (sleep_i) begin
      pend_q <= '0;
      left_q <= '0;
    end else begin
      if (tick_i && burst_i) left_q <= BW'(ROWS);
      else if (take_burst)   left_q <= left_q - BW'(1);
      if (add_pend && !take_pend)      pend_q <= pend_q + PW'(1);
      else if (!add_pend && take_pend) pend_q <= pend_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            win_q <= '0;
    else if (issue_o)       win_q <= CW'(BUSY);
    else if (win_q != '0)   win_q <= win_q - CW'(1);
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned ROWS     = 8192,
  parameter int unsigned INTERVAL = 1040,
  parameter int unsigned BUSY     = 4,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    burst_mode_i,
  input  logic                    cbr_mode_i,
  input  logic                    hot_i,
  input  logic                    sleep_i,
  input  logic                    acc_req_i,
  input  logic                    acc_busy_i,
  output logic                    acc_gnt_o,
  output logic                    ref_cmd_o,
  output logic                    ref_addr_vld_o,
  output logic [$clog2(ROWS)-1:0] ref_row_o,
  output logic                    ref_busy_o,
  output logic                    self_ref_o,
  output logic                    pass_done_o
);
  localparam int unsigned RW = $clog2(ROWS);

  logic          tick, issue, wrap;
  logic [RW-1:0] row;

  ref_timer #(.ROWS(ROWS), .INTERVAL(INTERVAL)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sleep_i),
    .burst_i (burst_mode_i),
    .hot_i   (hot_i),
    .tick_o  (tick)
  );

  ref_issue #(.ROWS(ROWS), .BUSY(BUSY), .MAX_PEND(MAX_PEND)) i_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .burst_i    (burst_mode_i),
    .sleep_i    (sleep_i),
    .acc_req_i  (acc_req_i),
    .acc_busy_i (acc_busy_i),
    .issue_o    (issue),
    .gnt_o      (acc_gnt_o),
    .busy_o     (ref_busy_o)
  );

  ref_row_ctr #(.ROWS(ROWS)) i_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (issue),
    .row_o  (row),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cmd_o      <= 1'b0;
      ref_addr_vld_o <= 1'b0;
      ref_row_o      <= '0;
      pass_done_o    <= 1'b0;
      self_ref_o     <= 1'b0;
    end else begin
      ref_cmd_o      <= issue;
      ref_addr_vld_o <= issue && !cbr_mode_i;
      ref_row_o      <= (issue && !cbr_mode_i) ? row : '0;
      pass_done_o    <= wrap;
      self_ref_o     <= sleep_i;
    end
  end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic acc_gnt_o,
  input logic ref_cmd_o,
  input logic ref_addr_vld_o,
  input logic ref_busy_o,
  input logic self_ref_o,
  input logic pass_done_o
);
  assert_gnt_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_busy_o |-> !acc_gnt_o);

  assert_cmd_opens_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |-> ref_busy_o);

  assert_quiet_in_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o |-> !ref_cmd_o);

  assert_addr_with_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_addr_vld_o |-> ref_cmd_o);

  assert_pass_with_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_done_o |-> ref_cmd_o);

  assert_cmd_spacing_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cmd_o |=> !ref_cmd_o);
endmodule

bind refresh_sched refresh_sched_chk i_refresh_sched_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_gnt_o      (acc_gnt_o),
  .ref_cmd_o      (ref_cmd_o),
  .ref_addr_vld_o (ref_addr_vld_o),
  .ref_busy_o     (ref_busy_o),
  .self_ref_o     (self_ref_o),
  .pass_done_o    (pass_done_o)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int ROWS     = 16;
  localparam int INTERVAL = 40;
  localparam int BUSY     = 4;
  localparam int MAX_PEND = 8;
  localparam int RW       = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n, burst, cbr, hot, sleep, acc_req, acc_busy;
  logic acc_gnt, ref_cmd, ref_vld, ref_busy, self_ref, pass_done;
  logic [RW-1:0] ref_row;

  always #4 clk = ~clk;

  refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .BUSY(BUSY), .MAX_PEND(MAX_PEND)) i_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .burst_mode_i(burst), .cbr_mode_i(cbr), .hot_i(hot),
    .sleep_i(sleep), .acc_req_i(acc_req), .acc_busy_i(acc_busy), .acc_gnt_o(acc_gnt),
    .ref_cmd_o(ref_cmd), .ref_addr_vld_o(ref_vld), .ref_row_o(ref_row), .ref_busy_o(ref_busy),
    .self_ref_o(self_ref), .pass_done_o(pass_done)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int ncmd = 0, last_cyc = 0, last_gap = 0, min_gap = 1000;
  int exp_row = 0, row_err = 0, pass_err = 0, pass_cnt = 0, gnt_err = 0;
  logic last_vld = 1'b0;
  int last_row = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor samples 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (acc_gnt && ref_busy) gnt_err++;
      if (ref_cmd) begin
        last_gap = cyc - last_cyc;
        if (ncmd > 0 && last_gap < min_gap) min_gap = last_gap;
        last_cyc = cyc;
        ncmd++;
        last_vld = ref_vld;
        last_row = int'(ref_row);
        if (ref_vld && int'(ref_row) != exp_row) row_err++;
        if (pass_done != (exp_row == ROWS - 1)) pass_err++;
        if (pass_done) pass_cnt++;
        exp_row = (exp_row + 1) % ROWS;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cmd(input int max);
    int start = ncmd;
    for (int k = 0; k < max && ncmd == start; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && ref_busy; k++) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(150000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog (all R): actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

  initial begin
    int rel, n0, p0, bad, busy_left;
    void'($urandom(32'd2024));
    rst_n = 1'b0; burst = 1'b0; cbr = 1'b0; hot = 1'b0; sleep = 1'b0;
    acc_req = 1'b0; acc_busy = 1'b0;
    tick(3);
    chk(!ref_cmd && !ref_busy && !self_ref, "R1 reset outputs", int'(ref_cmd), 0);
    chk(ref_row == '0, "R1 reset row", int'(ref_row), 0);
    rst_n = 1'b1;
    rel = cyc;

    // R1 first command, R2 spacing
    wait_cmd(200);
    chk(last_cyc - rel >= INTERVAL && last_cyc - rel <= INTERVAL + 2, "R1 first cmd delay",
        last_cyc - rel, INTERVAL);
    wait_cmd(200);
    chk(last_gap == INTERVAL, "R2 distributed spacing", last_gap, INTERVAL);
    for (int i = 0; i < 15; i++) wait_cmd(200);
    chk(pass_cnt == 1, "R11 one pass after ROWS+1 cmds", pass_cnt, 1);
    chk(row_err == 0 && last_vld, "R3 row sequence and valid", row_err, 0);

    // R5 busy window and grant
    acc_req = 1'b1;
    wait_cmd(200);
    bad = 0;
    while (ref_busy && bad < 50) begin
      bad++;
      tick(1);
    end
    chk(bad == BUSY, "R5 busy window length", bad, BUSY);
    chk(acc_gnt == 1'b1, "R5 grant after window", int'(acc_gnt), 1);

    // R4 counter-driven style
    cbr = 1'b1;
    wait_cmd(200);
    chk(!last_vld && last_row == 0, "R4 no address", int'(last_vld), 0);
    cbr = 1'b0;
    wait_cmd(200);
    chk(row_err == 0 && last_vld, "R3 row continues after bare cmd", row_err, 0);

    // R6 over-temperature
    hot = 1'b1;
    wait_cmd(200); wait_cmd(200); wait_cmd(200);
    chk(last_gap == INTERVAL / 2, "R6 halved spacing", last_gap, INTERVAL / 2);
    hot = 1'b0;
    wait_cmd(200); wait_cmd(200); wait_cmd(200);
    chk(last_gap == INTERVAL, "R6 normal spacing restored", last_gap, INTERVAL);

    // R8 postponement
    wait_cmd(200);
    acc_busy = 1'b1;
    n0 = ncmd;
    tick(3 * INTERVAL + 10);
    chk(ncmd == n0, "R8 no cmd while access busy", ncmd - n0, 0);
    acc_busy = 1'b0;
    wait_cmd(20);
    chk(ncmd == n0 + 1, "R8 first queued cmd", ncmd - n0, 1);
    wait_cmd(20);
    chk(last_gap == BUSY, "R8 queued cmd back to back", last_gap, BUSY);
    wait_cmd(20);
    chk(last_gap == BUSY, "R8 third queued cmd", last_gap, BUSY);

    // R9 queue limit
    wait_cmd(200);
    acc_busy = 1'b1;
    tick(60);
    chk(acc_gnt == 1'b1, "R9 grant below limit", int'(acc_gnt), 1);
    tick(8 * INTERVAL);
    chk(acc_gnt == 1'b0, "R9 grant withheld at limit", int'(acc_gnt), 0);
    n0 = ncmd;
    acc_busy = 1'b0;
    tick(40);
    chk(ncmd - n0 >= MAX_PEND, "R9 queue drained", ncmd - n0, MAX_PEND);
    wait_idle();
    chk(acc_gnt == 1'b1, "R9 grant after drain", int'(acc_gnt), 1);

    // R10 sleep
    wait_cmd(200);
    sleep = 1'b1;
    n0 = ncmd;
    tick(2);
    chk(self_ref == 1'b1, "R10 self-refresh shown", int'(self_ref), 1);
    tick(200);
    chk(ncmd == n0, "R10 no cmd in sleep", ncmd - n0, 0);
    sleep = 1'b0;
    rel = cyc;
    tick(2);
    chk(self_ref == 1'b0, "R10 self-refresh cleared", int'(self_ref), 0);
    wait_cmd(200);
    chk(last_cyc - rel >= INTERVAL && last_cyc - rel <= INTERVAL + 2, "R10 resume delay",
        last_cyc - rel, INTERVAL);

    // R7 burst
    burst = 1'b1;
    acc_req = 1'b1;
    wait_cmd(ROWS * INTERVAL + 50);
    p0 = pass_cnt - (pass_done ? 1 : 0);
    bad = 0;
    for (int i = 0; i < ROWS - 1; i++) begin
      wait_cmd(20);
      if (last_gap != BUSY) bad++;
    end
    chk(bad == 0, "R7 burst commands back to back", bad, 0);
    chk(pass_cnt - p0 == 1, "R7 burst covers array once", pass_cnt - p0, 1);
    n0 = ncmd;
    tick(2 * BUSY + 2);
    chk(ncmd == n0, "R7 burst ends after ROWS cmds", ncmd - n0, 0);
    chk(acc_gnt == 1'b1, "R7 grant after burst", int'(acc_gnt), 1);
    burst = 1'b0;

    // random traffic
    min_gap = 1000;
    n0 = ncmd;
    busy_left = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      acc_req = 1'($urandom % 2);
      if (busy_left > 0) busy_left--;
      else if ($urandom % 8 == 0) busy_left = int'($urandom % 12);
      acc_busy = (busy_left > 0);
    end
    acc_busy = 1'b0;
    tick(2);
    chk(min_gap >= BUSY, "R12 minimum command spacing", min_gap, BUSY);
    chk(gnt_err == 0, "R5 no grant during busy window", gnt_err, 0);
    chk(row_err == 0, "R3 row order under traffic", row_err, 0);
    chk(pass_err == 0, "R11 pass pulse placement", pass_err, 0);
    chk(ncmd - n0 >= 3000 / INTERVAL - 3, "R2 refresh rate kept", ncmd - n0, 3000 / INTERVAL);

    report();
    $finish;
  end
endmodule